// File: doc/BRIEF.md
# Interleaved DRAM Range Router

The router decides which memory node owns a 40-bit physical request address. It holds eight programmable windows. Each window is a pair of 32-bit words: a low-bound word and a high-bound word. The router compares every incoming request against all windows in parallel. It reports whether a window claimed the request, which window that was, and the node ID stored with that window.

Windows are aligned to 16 MB, because only the upper sixteen address bits take part in the bounds compare. Each window carries separate permission bits for reads and for writes. A window can also be split across 2, 4 or 8 nodes by interleaving on address bits 14:12. In that case a window claims only those addresses whose selected interleave bits equal a per-window select code. Software should write the high-bound word before the low-bound word, because the low-bound word holds the enables.

The lookup path is purely combinational from the request inputs and the stored words. Configuration writes are captured on the rising clock edge.

Top module: `dram_range_router`

## Requirements
- R1: After reset every window is disabled, so `hit`, `node` and `range_idx` are all 0 for any request.
- R2: Window i claims an address when lo[31:16] <= addr[39:24] <= hi[31:16]. Both bounds are inclusive.
- R3: Bit 0 of the low-bound word permits reads (`req_write`=0) and bit 1 permits writes (`req_write`=1). A request whose type is not permitted is never claimed by that window.
- R4: On a hit, `node` equals bits [2:0] of the high-bound word of the winning window.
- R5: Bits [10:8] of the low-bound word form an interleave mask, and bits [10:8] of the high-bound word form a select code. Every mask bit that is set requires the matching bit of addr[14:12] to equal the select bit. The codes used are 000 (none), 001 (bit 12), 011 (bits 13:12) and 111 (bits 14:12).
- R6: When several windows claim a request, the lowest index wins, and `range_idx` reports that index.
- R7: When no window claims a request, `hit`=0, `node`=0 and `range_idx`=0.
- R8: While `req_valid` is 0, `hit` is 0 whatever the address.
- R9: A write with `cfg_we`=1 stores `cfg_wdata` into window `cfg_idx`, in the low-bound word when `cfg_sel`=0 and in the high-bound word when `cfg_sel`=1. The new value applies from the next rising edge. With `cfg_we`=0 no word changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 3 | Window index to write |
| cfg_sel | input | 1 | 0 selects the low-bound word, 1 selects the high-bound word |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Request qualifier |
| req_write | input | 1 | Request type: 1 for write, 0 for read |
| req_addr | input | 40 | Physical request address |
| hit | output | 1 | A window claimed the request |
| node | output | 3 | Destination node of the winning window |
| range_idx | output | 3 | Index of the winning window |

## Verification
Two functions can decide the same request together: the bounds compare with its interleave filter, and the lowest-index priority pick. This happens when two windows overlap and only one of them passes the interleave test. The bench builds such overlapping windows, both by hand and by random programming of all eight windows, then sweeps addresses across and just outside their bounds with all interleave bit patterns. Each result is judged against a bench model that walks the windows in index order.

// File: rtl/dram_rt_pkg.sv
package dram_rt_pkg;
   localparam int WORD_W       = 32;
   localparam int RD_EN_BIT    = 0;
   localparam int WR_EN_BIT    = 1;
   localparam int ILV_FLD_LSB  = 8;
   localparam int NODE_FLD_LSB = 0;
   localparam int BND_FLD_MSB  = 31;

   typedef enum logic {
      WORD_LO = 1'b0,
      WORD_HI = 1'b1
   } word_sel_e;
endpackage

// File: rtl/dram_rt_regs.sv
module dram_rt_regs
   import dram_rt_pkg::*;
#(
   parameter int N_WIN = 8,
   localparam int IDX_W = $clog2(N_WIN)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          we,
   input  logic [IDX_W-1:0]              idx,
   input  logic                          sel,
   input  logic [WORD_W-1:0]             wdata,
   output logic [N_WIN-1:0][WORD_W-1:0]  lo_q,
   output logic [N_WIN-1:0][WORD_W-1:0]  hi_q
);
   initial begin
      if (N_WIN < 2) $fatal(1, "N_WIN must be at least 2");
   end

   for (genvar gi = 0; gi < N_WIN; gi++) begin : g_win
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lo_q[gi] <= '0;
            hi_q[gi] <= '0;
         end else if (we && idx == IDX_W'(gi)) begin
            if (word_sel_e'(sel) == WORD_HI) hi_q[gi] <= wdata;
            else                             lo_q[gi] <= wdata;
         end
      end
   end

   // R9: no word moves without a write strobe
   p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> ($stable(lo_q) && $stable(hi_q)));
endmodule

// File: rtl/dram_rt_match.sv
module dram_rt_match
   import dram_rt_pkg::*;
#(
   parameter int ADDR_W  = 40,
   parameter int BND_W   = 16,
   parameter int ILV_W   = 3,
   parameter int ILV_LSB = 12,
   parameter bit ILV_ON  = 1'b1
) (
   input  logic [WORD_W-1:0] lo_word,
   input  logic [WORD_W-1:0] hi_word,
   input  logic [ADDR_W-1:0] addr,
   input  logic              is_write,
   input  logic              valid,
   output logic              claim
);
   initial begin
      if (BND_W > 16 || BND_W < 1) $fatal(1, "BND_W out of range");
      if (ILV_W > 3 || ILV_W < 1)  $fatal(1, "ILV_W out of range");
      if (ILV_LSB + ILV_W > ADDR_W - BND_W) $fatal(1, "interleave bits overlap bound field");
   end

   logic [BND_W-1:0] lo_f, hi_f, a_f;
   logic             perm, in_bounds, ilv_ok;

   assign lo_f = lo_word[BND_FLD_MSB -: BND_W];
   assign hi_f = hi_word[BND_FLD_MSB -: BND_W];
   assign a_f  = addr[ADDR_W-1 -: BND_W];
   assign perm = is_write ? lo_word[WR_EN_BIT] : lo_word[RD_EN_BIT];
   assign in_bounds = (a_f >= lo_f) && (a_f <= hi_f);

   if (ILV_ON) begin : g_ilv
      logic [ILV_W-1:0] mask, code, abits;
      assign mask   = lo_word[ILV_FLD_LSB +: ILV_W];
      assign code   = hi_word[ILV_FLD_LSB +: ILV_W];
      assign abits  = addr[ILV_LSB +: ILV_W];
      assign ilv_ok = ((abits ^ code) & mask) == '0;
   end else begin : g_no_ilv
      assign ilv_ok = 1'b1;
   end

   assign claim = valid && perm && in_bounds && ilv_ok;
endmodule

// File: rtl/dram_rt_prio.sv
module dram_rt_prio #(
   parameter int N_WIN = 8,
   localparam int IDX_W = $clog2(N_WIN)
) (
   input  logic [N_WIN-1:0] req,
   output logic             any,
   output logic [IDX_W-1:0] win
);
   always_comb begin
      win = '0;
      for (int i = N_WIN - 1; i >= 0; i--) begin
         if (req[i]) win = IDX_W'(i);
      end
   end
   assign any = |req;
endmodule

// File: rtl/dram_range_router.sv
module dram_range_router
   import dram_rt_pkg::*;
#(
   parameter int N_WIN   = 8,
   parameter int ADDR_W  = 40,
   parameter int GRAN_W  = 24,
   parameter int NODE_W  = 3,
   parameter int ILV_W   = 3,
   parameter int ILV_LSB = 12,
   parameter bit ILV_ON  = 1'b1,
   localparam int IDX_W  = $clog2(N_WIN),
   localparam int BND_W  = ADDR_W - GRAN_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  logic              cfg_sel,
   input  logic [31:0]       cfg_wdata,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              hit,
   output logic [NODE_W-1:0] node,
   output logic [IDX_W-1:0]  range_idx
);
   initial begin
      if (NODE_W > ILV_FLD_LSB) $fatal(1, "node field collides with interleave field");
      if (WORD_W != 32)         $fatal(1, "word width must be 32");
   end

   logic [N_WIN-1:0][WORD_W-1:0] lo_q, hi_q;
   logic [N_WIN-1:0]             claims;
   logic                         any;
   logic [IDX_W-1:0]             win;

   dram_rt_regs #(.N_WIN(N_WIN)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .idx(cfg_idx), .sel(cfg_sel),
      .wdata(cfg_wdata), .lo_q(lo_q), .hi_q(hi_q)
   );

   for (genvar gi = 0; gi < N_WIN; gi++) begin : g_cmp
      dram_rt_match #(
         .ADDR_W(ADDR_W), .BND_W(BND_W), .ILV_W(ILV_W),
         .ILV_LSB(ILV_LSB), .ILV_ON(ILV_ON)
      ) u_match (
         .lo_word(lo_q[gi]), .hi_word(hi_q[gi]), .addr(req_addr),
         .is_write(req_write), .valid(req_valid), .claim(claims[gi])
      );
   end

   dram_rt_prio #(.N_WIN(N_WIN)) u_prio (.req(claims), .any(any), .win(win));

   assign hit       = any;
   assign range_idx = any ? win : '0;
   assign node      = any ? hi_q[win][NODE_FLD_LSB +: NODE_W] : '0;

   // R7: a miss drives zero on node and index
   p_miss_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |-> (node == '0 && range_idx == '0));
   // R8: an unqualified request is never claimed
   p_idle_no_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> !hit);
   // R6: the reported window claimed the request and no lower one did
   p_lowest_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (claims[range_idx] &&
               ((claims & ((N_WIN'(1) << range_idx) - N_WIN'(1))) == '0)));
   // R2: a hit lies inside the winner's bounds
   p_in_bounds_r2: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (req_addr[ADDR_W-1 -: BND_W] >= lo_q[range_idx][BND_FLD_MSB -: BND_W] &&
               req_addr[ADDR_W-1 -: BND_W] <= hi_q[range_idx][BND_FLD_MSB -: BND_W]));
   // R3: the winner permits the request type
   p_perm_r3: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (req_write ? lo_q[range_idx][WR_EN_BIT] : lo_q[range_idx][RD_EN_BIT]));
endmodule

// File: tb/dram_range_router_test.sv
module dram_range_router_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_idx = '0;
   logic        cfg_sel = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [39:0] req_addr = '0;
   logic        hit;
   logic [2:0]  node;
   logic [2:0]  range_idx;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done = 1'b0;

   logic [31:0] m_lo [8];
   logic [31:0] m_hi [8];

   always #(CLK_PERIOD/2) clk = ~clk;

   dram_range_router uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
      .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
      .req_write(req_write), .req_addr(req_addr), .hit(hit), .node(node),
      .range_idx(range_idx)
   );

   function automatic logic [31:0] mk_lo(logic [15:0] f, logic [2:0] ilv, bit wr, bit rd);
      return {f, 5'b0, ilv, 6'b0, wr, rd};
   endfunction

   function automatic logic [31:0] mk_hi(logic [15:0] f, logic [2:0] code, logic [2:0] nd);
      return {f, 5'b0, code, 5'b0, nd};
   endfunction

   function automatic logic [6:0] expect_of(logic [39:0] a, bit wr, bit v);
      for (int i = 0; i < 8; i++) begin
         logic perm;
         perm = wr ? m_lo[i][1] : m_lo[i][0];
         if (v && perm && a[39:24] >= m_lo[i][31:16] && a[39:24] <= m_hi[i][31:16] &&
             ((a[14:12] ^ m_hi[i][10:8]) & m_lo[i][10:8]) == 3'b000)
            return {1'b1, m_hi[i][2:0], 3'(i)};
      end
      return 7'b0;
   endfunction

   task automatic cfg(input int idx, input bit sel, input logic [31:0] d, input bit we);
      @(negedge clk);
      cfg_we = we; cfg_idx = 3'(idx); cfg_sel = sel; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      if (we) begin
         if (sel) m_hi[idx] = d; else m_lo[idx] = d;
      end
   endtask

   task automatic probe(input logic [39:0] a, input bit wr, input bit v, input string tag);
      logic [6:0] e;
      @(negedge clk);
      req_addr = a; req_write = wr; req_valid = v;
      #1;
      e = expect_of(a, wr, v);
      checks++;
      if ({hit, node, range_idx} !== e) begin
         errors++;
         $display("FAIL %s addr=%h wr=%0d got hit=%0d node=%0d idx=%0d exp hit=%0d node=%0d idx=%0d",
                  tag, a, wr, hit, node, range_idx, e[6], e[5:3], e[2:0]);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      for (int i = 0; i < 8; i++) begin m_lo[i] = '0; m_hi[i] = '0; end
      void'($urandom(32'd5171));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state, all windows off
      probe({16'h0000, 24'h0}, 1'b0, 1'b1, "R1 reset read");
      probe({16'hFFFF, 24'hFFF}, 1'b1, 1'b1, "R1 reset write");

      // R2 R4 R9: window 2, 0x10..0x13, node 5
      cfg(2, 1'b1, mk_hi(16'h0013, 3'd0, 3'd5), 1'b1);
      cfg(2, 1'b0, mk_lo(16'h0010, 3'b000, 1'b1, 1'b1), 1'b1);
      probe({16'h0010, 24'h000000}, 1'b0, 1'b1, "R2 low bound");
      probe({16'h0013, 24'hFFFFFF}, 1'b1, 1'b1, "R2 high bound R4 node");
      probe({16'h0014, 24'h000000}, 1'b0, 1'b1, "R7 above limit");
      probe({16'h000F, 24'hFFFFFF}, 1'b0, 1'b1, "R7 below base");

      // R3: window 3 read only, window 4 write only
      cfg(3, 1'b1, mk_hi(16'h0020, 3'd0, 3'd1), 1'b1);
      cfg(3, 1'b0, mk_lo(16'h0020, 3'b000, 1'b0, 1'b1), 1'b1);
      cfg(4, 1'b1, mk_hi(16'h0030, 3'd0, 3'd2), 1'b1);
      cfg(4, 1'b0, mk_lo(16'h0030, 3'b000, 1'b1, 1'b0), 1'b1);
      probe({16'h0020, 24'h123456}, 1'b0, 1'b1, "R3 read allowed");
      probe({16'h0020, 24'h123456}, 1'b1, 1'b1, "R3 write blocked");
      probe({16'h0030, 24'h00ABCD}, 1'b1, 1'b1, "R3 write allowed");
      probe({16'h0030, 24'h00ABCD}, 1'b0, 1'b1, "R3 read blocked");

      // R5: window 5 mask 011 code 010, window 6 mask 111 code 011, same bounds
      cfg(5, 1'b1, mk_hi(16'h0040, 3'b010, 3'd6), 1'b1);
      cfg(5, 1'b0, mk_lo(16'h0040, 3'b011, 1'b1, 1'b1), 1'b1);
      cfg(6, 1'b1, mk_hi(16'h0040, 3'b011, 3'd7), 1'b1);
      cfg(6, 1'b0, mk_lo(16'h0040, 3'b111, 1'b1, 1'b1), 1'b1);
      probe({16'h0040, 9'h0, 3'b010, 12'h0}, 1'b0, 1'b1, "R5 ilv 010");
      probe({16'h0040, 9'h0, 3'b110, 12'hFFF}, 1'b0, 1'b1, "R5 ilv masked bit14");
      probe({16'h0040, 9'h0, 3'b011, 12'h0}, 1'b0, 1'b1, "R5 R6 falls to window 6");
      probe({16'h0040, 9'h0, 3'b111, 12'h0}, 1'b0, 1'b1, "R5 no window");
      probe({16'h0040, 9'h0, 3'b000, 12'h0}, 1'b1, 1'b1, "R5 no window 000");

      // R6: window 0 overlaps window 2
      cfg(0, 1'b1, mk_hi(16'h0011, 3'd0, 3'd3), 1'b1);
      cfg(0, 1'b0, mk_lo(16'h0011, 3'b001, 1'b1, 1'b1), 1'b1);
      probe({16'h0011, 24'h000000}, 1'b0, 1'b1, "R6 lowest index");
      probe({16'h0011, 24'h001000}, 1'b0, 1'b1, "R6 R5 ilv bit12 to window 2");

      // R8: unqualified request
      probe({16'h0011, 24'h000000}, 1'b0, 1'b0, "R8 valid low");
      // R9: strobe low leaves window 0 intact
      cfg(0, 1'b0, 32'h0, 1'b0);
      probe({16'h0011, 24'h000000}, 1'b0, 1'b1, "R9 no write without strobe");

      // random programming of all windows, then address sweeps
      for (int round = 0; round < 6; round++) begin
         for (int w = 0; w < 8; w++) begin
            logic [15:0] b, l;
            logic [2:0]  ilv;
            int pick;
            b = 16'($urandom_range(0, 40));
            l = b + 16'($urandom_range(0, 8));
            pick = $urandom_range(0, 3);
            ilv = (pick == 0) ? 3'b000 : (pick == 1) ? 3'b001 : (pick == 2) ? 3'b011 : 3'b111;
            cfg(w, 1'b1, mk_hi(l, 3'($urandom), 3'($urandom)), 1'b1);
            cfg(w, 1'b0, mk_lo(b, ilv, 1'($urandom), 1'($urandom)), 1'b1);
         end
         for (int k = 0; k < 120; k++) begin
            logic [39:0] a;
            a = {16'($urandom_range(0, 52)), 24'($urandom)};
            probe(a, 1'($urandom), ($urandom_range(0, 9) != 0), "R2 R3 R4 R5 R6 random");
         end
      end
      finish_run();
   end
endmodule